// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a countdown watchdog that tolerates one missed service before it asks for a system reset. A reload register sets the countdown value. The counter steps down once for every pulse on the period tick input. When it expires it reloads itself. If the expire flag is clear at that moment, the block only sets the flag, which software sees in a status register. If the flag is still set from an earlier expiry, the block raises a one-cycle reset request and then returns every register to its reset value.

Software keeps the system alive in two steps. It writes to a kick offset, which reloads the countdown. It writes a one to the flag bit, which clears the flag. A control bit hands clearing of the flag to an external management agent, which pulses a strobe. That bit is set out of reset, so the watchdog starts disarmed. Software clears the bit to arm the watchdog.

The register port is a flat byte offset with a write strobe and write data, plus a combinational read-data output. Only the four offsets listed below are decoded.

Top module: `twostrike_wdog`

## Requirements
- R1: After reset, the four offsets read as follows: status (0x04) reads 0, control (0x30) reads 0x2000, reload (0x08) reads the RELOAD_INIT parameter (default 15). reset_req_o is 0.
- R2: The counter steps down by one on each cycle with tick_i high. The expiry happens on the tick that finds the count at zero, so one timeout period lasts reload+1 ticks. At expiry the counter loads the reload value again.
- R3: An expiry while the expire flag (status bit 3) is clear sets the flag, so status reads 0x0008. It does not raise reset_req_o.
- R4: An expiry while the flag is set drives reset_req_o high for exactly one cycle, starting in the cycle after that tick. From that cycle on, all registers hold their R1 values.
- R5: A write to status with data bit 3 set clears the flag. A write with bit 3 clear has no effect, whatever the other bits are. Status bits other than bit 3 always read 0.
- R6: Any write to offset 0x00 (kick) loads the counter with the reload value. A kick takes priority over a tick in the same cycle, so that tick causes no expiry.
- R7: When control bit 13 is 1, a mgmt_clear_i pulse clears the flag. When bit 13 is 0, mgmt_clear_i has no effect.
- R8: With reload R and tick_i high every cycle, a hang that starts just after a kick with the flag clear reaches reset_req_o after 2(R+1) ticks. A hang that starts with the flag already set and a fresh kick reaches it after R+1 ticks.
- R9: The reload register at 0x08 is 10 bits wide and reads back what was written. A new value takes effect at the next kick or expiry reload.
- R10: A flag clear, by status write or by management strobe, in the same cycle as an expiry takes effect first. That expiry then counts as a first strike: the flag is set again and no reset is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W (8) | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | DATA_W (16) | Write data |
| rd_data_o | output | DATA_W (16) | Read data for addr_i, combinational |
| tick_i | input | 1 | One-cycle pulse per countdown period |
| mgmt_clear_i | input | 1 | Flag-clear strobe from the management agent |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The properties assume that tick_i, mgmt_clear_i and the write strobe are held stable and are sampled once per clock. They also assume that the reload value fits the 10-bit field, so a write never collides with a pending soft reset other than through the defined priority. The stimulus changes inputs only just after a falling edge. It schedules ticks, kicks and flag clears deliberately, including the same-cycle collisions of R6 and R10, and the behavioural model is compared against the outputs on every falling edge.

// File: rtl/tswd_pkg.sv
package tswd_pkg;

    // register offsets
    localparam int unsigned OFS_KICK   = 32'h00;
    localparam int unsigned OFS_STATUS = 32'h04;
    localparam int unsigned OFS_RELOAD = 32'h08;
    localparam int unsigned OFS_CTRL   = 32'h30;

    // field positions
    localparam int unsigned FLAG_POS = 3;
    localparam int unsigned AUTO_POS = 13;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_KICK,
        RS_STATUS,
        RS_RELOAD,
        RS_CTRL
    } reg_sel_e;

endpackage

// File: rtl/tswd_regs.sv
module tswd_regs
    import tswd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned RELOAD_INIT = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              flag_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              auto_clr_o,
    output logic              kick_o,
    output logic              w1c_o
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             auto_clr;
    } regs_t;

    localparam regs_t REGS_RST = '{reload: CNT_W'(RELOAD_INIT), auto_clr: 1'b1};

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     unused_wdata;

    assign unused_wdata = ^wr_data_i;

    always_comb begin
        if (addr_i == ADDR_W'(OFS_KICK))        sel = RS_KICK;
        else if (addr_i == ADDR_W'(OFS_STATUS)) sel = RS_STATUS;
        else if (addr_i == ADDR_W'(OFS_RELOAD)) sel = RS_RELOAD;
        else if (addr_i == ADDR_W'(OFS_CTRL))   sel = RS_CTRL;
        else                                    sel = RS_NONE;
    end

    always_comb begin
        regs_d = regs_q;
        if (soft_rst_i) begin
            regs_d = REGS_RST;
        end else if (wr_en_i) begin
            case (sel)
                RS_RELOAD: regs_d.reload   = wr_data_i[CNT_W-1:0];
                RS_CTRL:   regs_d.auto_clr = wr_data_i[AUTO_POS];
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) regs_q <= REGS_RST;
        else         regs_q <= regs_d;
    end

    always_comb begin
        rd_data_o = '0;
        case (sel)
            RS_STATUS: rd_data_o[FLAG_POS]   = flag_i;
            RS_RELOAD: rd_data_o[CNT_W-1:0]  = regs_q.reload;
            RS_CTRL:   rd_data_o[AUTO_POS]   = regs_q.auto_clr;
            default:   rd_data_o = '0;
        endcase
    end

    assign reload_o   = regs_q.reload;
    assign auto_clr_o = regs_q.auto_clr;
    assign kick_o     = wr_en_i && (sel == RS_KICK);
    assign w1c_o      = wr_en_i && (sel == RS_STATUS) && wr_data_i[FLAG_POS];

    // R9
    reload_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADDR_W'(OFS_RELOAD) && !soft_rst_i)
        |=> (reload_o == $past(wr_data_i[CNT_W-1:0])));

endmodule

// File: rtl/tswd_counter.sv
module tswd_counter #(
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned RELOAD_INIT = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             soft_rst_i,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    localparam cnt_t CNT_RST = '{cnt: CNT_W'(RELOAD_INIT)};

    cnt_t cnt_d, cnt_q;

    assign expire_o = tick_i && !kick_i && (cnt_q.cnt == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (soft_rst_i) begin
            cnt_d = CNT_RST;
        end else if (kick_i) begin
            cnt_d.cnt = reload_i;
        end else if (tick_i) begin
            if (cnt_q.cnt == '0) cnt_d.cnt = reload_i;
            else                 cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= CNT_RST;
        else         cnt_q <= cnt_d;
    end

    // R2
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !kick_i && cnt_q.cnt != '0)
        |=> (cnt_q.cnt == $past(cnt_q.cnt) - 1'b1));

    // R6
    kick_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_i |=> (cnt_q.cnt == $past(reload_i)));

endmodule

// File: rtl/twostrike_wdog.sv
module twostrike_wdog
    import tswd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned RELOAD_INIT = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              tick_i,
    input  logic              mgmt_clear_i,
    output logic              reset_req_o
);

    typedef struct packed {
        logic flag;
        logic req;
    } strike_t;

    localparam strike_t STRIKE_RST = '{flag: 1'b0, req: 1'b0};

    strike_t          st_d, st_q;
    logic [CNT_W-1:0] reload;
    logic             auto_clr, kick, w1c, expire;
    logic             clr_now, flag_eff, strike2;

    tswd_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (strike2),
        .addr_i     (addr_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .flag_i     (st_q.flag),
        .rd_data_o  (rd_data_o),
        .reload_o   (reload),
        .auto_clr_o (auto_clr),
        .kick_o     (kick),
        .w1c_o      (w1c)
    );

    tswd_counter #(
        .CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (strike2),
        .tick_i     (tick_i),
        .kick_i     (kick),
        .reload_i   (reload),
        .expire_o   (expire)
    );

    always_comb begin
        clr_now  = w1c || (mgmt_clear_i && auto_clr);
        flag_eff = st_q.flag && !clr_now;
        strike2  = expire && flag_eff;
        st_d.req  = strike2;
        st_d.flag = strike2 ? 1'b0 : (expire || flag_eff);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= STRIKE_RST;
        else         st_q <= st_d;
    end

    assign reset_req_o = st_q.req;

    // R4
    req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reset_req_o |=> !reset_req_o);

    // R4
    req_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(reset_req_o) |-> $past(st_q.flag));

    // R3
    first_strike_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire && !st_q.flag) |=> (st_q.flag && !reset_req_o));

    // R7
    mgmt_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!auto_clr && mgmt_clear_i && !w1c && st_q.flag && !expire) |=> st_q.flag);

endmodule

// File: tb/twostrike_wdog_bench.sv
`timescale 1ns/1ps
module twostrike_wdog_bench;

    localparam int RINIT = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        tick = 1'b0;
    logic        mgmt = 1'b0;
    logic        req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    twostrike_wdog #(.RELOAD_INIT(RINIT)) u_twostrike_wdog (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wdata), .rd_data_o(rdata), .tick_i(tick),
        .mgmt_clear_i(mgmt), .reset_req_o(req)
    );

    // behavioural reference model
    int m_cnt, m_reload, m_flag, m_auto, m_req;

    always @(posedge clk) begin
        bit kk, w1, clr, ex, f;
        if (!rst_n) begin
            m_cnt = RINIT; m_reload = RINIT; m_flag = 0; m_auto = 1; m_req = 0;
        end else begin
            kk  = wr_en && addr == 8'h00;
            w1  = wr_en && addr == 8'h04 && wdata[3];
            clr = w1 || (mgmt && m_auto != 0);
            ex  = tick && !kk && m_cnt == 0;
            f   = (m_flag != 0) && !clr;
            m_req = 0;
            if (ex && f) begin
                m_cnt = RINIT; m_reload = RINIT; m_flag = 0; m_auto = 1; m_req = 1;
            end else begin
                m_flag = (ex || f) ? 1 : 0;
                if (kk) m_cnt = m_reload;
                else if (tick) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
                if (wr_en && addr == 8'h08) m_reload = int'(wdata[9:0]);
                if (wr_en && addr == 8'h30) m_auto = int'(wdata[13]);
            end
        end
    end

    function automatic int model_read(input logic [7:0] a);
        case (a)
            8'h04:   return m_flag << 3;
            8'h08:   return m_reload;
            8'h30:   return m_auto << 13;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 model reset_req", int'(req), m_req);
            check("R5 model readback", int'(rdata), model_read(addr));
        end
    end

    task automatic cyc(input logic t, input logic m, input logic we,
                       input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        tick = t; mgmt = m; wr_en = we; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        cyc(0, 0, 0, a, 16'h0);
        #1 v = int'(rdata);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 8'h00, 16'h0);
    endtask

    task automatic hang(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            cyc(1, 0, 0, 8'h00, 16'h0);
            n++;
            @(posedge clk); #1;
            if (req) break;
        end
        cyc(0, 0, 0, 8'h00, 16'h0);
        @(posedge clk); #1;
        check("R4 pulse width one cycle", int'(req), 0);
    endtask

    task automatic setup(input int rl);
        cyc(0, 0, 1, 8'h08, 16'(rl));
        cyc(0, 0, 1, 8'h30, 16'h0000);
        cyc(0, 0, 1, 8'h00, 16'h0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int v, n;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, v); check("R1 status after reset", v, 0);
        rd(8'h30, v); check("R1 control after reset", v, 16'h2000);
        rd(8'h08, v); check("R1 reload after reset", v, RINIT);
        check("R1 reset_req after reset", int'(req), 0);

        // R8 worst case, R9 readback, R4 return to reset state
        setup(5);
        rd(8'h08, v); check("R9 reload readback", v, 5);
        hang(n); check("R8 worst-case ticks to reset", n, 12);
        rd(8'h30, v); check("R4 control back to reset", v, 16'h2000);
        rd(8'h08, v); check("R4 reload back to reset", v, RINIT);
        rd(8'h04, v); check("R4 status back to reset", v, 0);

        // R2, R3, then R8 best case
        setup(5);
        ticks(5);
        rd(8'h04, v); check("R2 no expiry before reload+1 ticks", v, 0);
        ticks(1);
        rd(8'h04, v); check("R3 first expiry sets flag", v, 16'h0008);
        check("R3 no reset on first expiry", int'(req), 0);
        cyc(0, 0, 1, 8'h00, 16'h0);
        hang(n); check("R8 best-case ticks to reset", n, 6);

        // R5 write-one-to-clear
        setup(5);
        ticks(6);
        cyc(0, 0, 1, 8'h04, 16'h0000);
        rd(8'h04, v); check("R5 write zero keeps flag", v, 16'h0008);
        cyc(0, 0, 1, 8'h04, 16'hFFF7);
        rd(8'h04, v); check("R5 other bits do not clear", v, 16'h0008);
        cyc(0, 0, 1, 8'h04, 16'h0008);
        rd(8'h04, v); check("R5 write one clears flag", v, 0);

        // R7 management clear
        cyc(0, 0, 1, 8'h00, 16'h0);
        ticks(6);
        cyc(0, 1, 0, 8'h00, 16'h0);
        rd(8'h04, v); check("R7 strobe ignored when bit13=0", v, 16'h0008);
        cyc(0, 0, 1, 8'h30, 16'h2000);
        cyc(0, 1, 0, 8'h00, 16'h0);
        rd(8'h04, v); check("R7 strobe clears when bit13=1", v, 0);
        cyc(0, 0, 1, 8'h30, 16'h0000);

        // R10 clear coincides with expiry
        cyc(0, 0, 1, 8'h00, 16'h0);
        ticks(6);
        ticks(5);
        cyc(1, 0, 1, 8'h04, 16'h0008);
        rd(8'h04, v); check("R10 clear wins, flag set again", v, 16'h0008);
        check("R10 no reset on coincident clear", int'(req), 0);

        // R6 kick beats tick
        ticks(5);
        cyc(1, 0, 1, 8'h00, 16'h0);
        rd(8'h04, v); check("R6 kick suppresses expiry", v, 16'h0008);
        check("R6 no reset with kick priority", int'(req), 0);
        hang(n); check("R6 counter reloaded by kick", n, 6);

        // R9 new reload value used at next reload
        setup(2);
        hang(n); check("R9 shorter reload period", n, 6);

        // R2 auto-reload after expiry
        setup(3);
        ticks(4);
        cyc(0, 0, 1, 8'h04, 16'h0008);
        ticks(3);
        rd(8'h04, v); check("R2 auto-reload keeps counting", v, 0);
        ticks(1);
        rd(8'h04, v); check("R2 second period expiry", v, 16'h0008);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule